// File: doc/BRIEF.md
# Event and Cycle Performance Monitor

This block measures what a processor pipeline is doing. It has three counters of equal width. A cycle counter advances on every clock while the monitor is enabled. Two event counters each watch one line picked from an event bus. An event counter counts in one of two ways. In occurrence mode it counts rising edges of its line. In duration mode it counts the clocks during which its line is high. A cycle count read next to a duration count gives the fraction of time that a condition held.

Software reaches the block through a register port with four indices. Index 0 is the control word, index 1 the cycle counter, index 2 event counter 0 and index 3 event counter 1. The port works only while the privileged-mode input is high. A counter that passes its maximum wraps to zero, keeps counting, and sets a sticky overflow flag. The flags together with per-counter enables drive a single interrupt request. A control bit steers that request to either the normal or the fast interrupt output.

Control word layout (W1C means write 1 to clear):

| Bit(s) | Meaning |
|--------|---------|
| 0 | global count enable |
| 1 | clear both event counters (self-clearing, reads 0) |
| 2 | clear cycle counter (self-clearing, reads 0) |
| 3 | interrupt route: 0 = normal output, 1 = fast output |
| 4 / 5 / 6 | interrupt enable for event counter 0 / event counter 1 / cycle counter |
| 8 / 9 / 10 | overflow flag for event counter 0 / event counter 1 / cycle counter, W1C |
| 12 / 13 | mode of event counter 0 / 1: 0 = occurrence, 1 = duration |
| 23:16 / 31:24 | event line select for event counter 0 / 1 |

Top module: `pmu_top`

## Requirements
- R1: After reset all three counters and the control word read 0, and both interrupt outputs are low.
- R2: A privileged write to index 1, 2 or 3 loads the cycle counter, event counter 0 or event counter 1 with the low CNT_W bits of the write data. A read returns the counter zero-extended to 32 bits.
- R3: While control bit 0 is set, the cycle counter adds one on every clock. From all ones it wraps to zero and sets the flag at bit 10.
- R4: In occurrence mode (mode bit 0), an enabled event counter adds one for each rising edge of the line named by its select field. A select value at or beyond NUM_EVT stands for a line that is always low.
- R5: In duration mode (mode bit 1), an enabled event counter adds one on every clock that its selected line is high. Event counter 0 sets flag bit 8 when it wraps, and event counter 1 sets flag bit 9.
- R6: While the debug input is high, both event counters hold their value. The cycle counter keeps counting.
- R7: Writing the control word with bit 1 set clears both event counters. Bit 2 clears the cycle counter. Both bits read back as 0.
- R8: Overflow flags stay set until a privileged control write puts a 1 in their position. If an overflow happens in the same cycle as that write, the flag stays set.
- R9: A counter keeps counting after it wraps, for as long as control bit 0 stays set.
- R10: The interrupt request is the OR of each overflow flag ANDed with its enable (bits 4 to 6). It appears on irq_o when bit 3 is 0 and on fiq_o when bit 3 is 1. The two outputs are never high together.
- R11: While priv_i is low, writes change nothing and reads return 0.
- R12: A direct write to a counter wins over that counter's increment in the same cycle, and no overflow flag is set for it in that cycle. With bit 0 clear, all counters hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | clock |
| rst_i | input | 1 | synchronous active-high reset |
| priv_i | input | 1 | privileged-mode qualifier for register access |
| dbg_i | input | 1 | debug mode; freezes the event counters |
| reg_wr_i | input | 1 | register write strobe |
| reg_rd_i | input | 1 | register read strobe |
| reg_idx_i | input | 2 | register index (0 control, 1 cycle, 2 event 0, 3 event 1) |
| reg_wdata_i | input | 32 | write data |
| reg_rdata_o | output | 32 | read data, combinational, 0 unless a privileged read is active |
| evt_i | input | NUM_EVT | event lines to choose from |
| irq_o | output | 1 | normal interrupt request |
| fiq_o | output | 1 | fast interrupt request |

## Verification
The bench builds the block with CNT_W = 8 and NUM_EVT = 4. With 8-bit counters, a wrap happens within a few dozen clocks of a load near the top. That brings overflow, wrap-through counting, the clash between a flag clear and a new overflow, and a load that lands on the wrap cycle within a short run. With four event lines, a select of 7 is out of range, so the constant-low case is tested as well. A behavioural model runs alongside the block and is compared every clock against the read data and both interrupt outputs.

// File: rtl/pmu_pkg.sv
package pmu_pkg;

    localparam int unsigned WORD_W  = 32;
    localparam int unsigned IDX_W   = 2;
    localparam int unsigned NUM_ECH = 2;            // event counter channels
    localparam int unsigned SRC_W   = NUM_ECH + 1;  // overflow sources, cycle counter on top
    localparam int unsigned SEL_FW  = 8;

    // control word bit positions
    localparam int unsigned B_EN       = 0;
    localparam int unsigned B_EVCLR    = 1;
    localparam int unsigned B_CYCLR    = 2;
    localparam int unsigned B_ROUTE    = 3;
    localparam int unsigned B_IE_LSB   = 4;
    localparam int unsigned B_OF_LSB   = 8;
    localparam int unsigned B_MODE_LSB = 12;
    localparam int unsigned B_SEL_LSB  = 16;

    typedef enum logic [IDX_W-1:0] {
        IDX_CTRL = 2'd0,
        IDX_CYC  = 2'd1,
        IDX_EV0  = 2'd2,
        IDX_EV1  = 2'd3
    } reg_idx_e;

    typedef enum logic {
        MODE_OCCUR = 1'b0,
        MODE_DUR   = 1'b1
    } evt_mode_e;

    typedef struct packed {
        logic [NUM_ECH-1:0][SEL_FW-1:0] sel;
        logic [NUM_ECH-1:0]             mode;
        logic [SRC_W-1:0]               ie;
        logic                           route_fiq;
        logic                           enable;
    } pmu_cfg_t;

    function automatic pmu_cfg_t cfg_decode(input logic [WORD_W-1:0] w);
        pmu_cfg_t c;
        c.enable    = w[B_EN];
        c.route_fiq = w[B_ROUTE];
        c.ie        = w[B_IE_LSB +: SRC_W];
        for (int i = 0; i < NUM_ECH; i++) begin
            c.mode[i] = w[B_MODE_LSB + i];
            c.sel[i]  = w[B_SEL_LSB + i*SEL_FW +: SEL_FW];
        end
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] ctrl_encode(input pmu_cfg_t c,
                                                      input logic [SRC_W-1:0] of);
        logic [WORD_W-1:0] w;
        w = '0;
        w[B_EN]                = c.enable;
        w[B_ROUTE]             = c.route_fiq;
        w[B_IE_LSB +: SRC_W]   = c.ie;
        w[B_OF_LSB +: SRC_W]   = of;
        for (int i = 0; i < NUM_ECH; i++) begin
            w[B_MODE_LSB + i]                   = c.mode[i];
            w[B_SEL_LSB + i*SEL_FW +: SEL_FW]   = c.sel[i];
        end
        return w;
    endfunction

endpackage

// File: rtl/pmu_counter.sv
module pmu_counter #(
    parameter int unsigned W = 32
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         clr_i,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         inc_i,
    output logic [W-1:0] count_o,
    output logic         wrap_o
);
    logic [W-1:0] cnt_q;

    // a wrap only counts when the increment is not overridden
    assign wrap_o  = inc_i & ~clr_i & ~load_i & (&cnt_q);
    assign count_o = cnt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i)       cnt_q <= '0;
        else if (clr_i)  cnt_q <= '0;
        else if (load_i) cnt_q <= load_val_i;
        else if (inc_i)  cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/pmu_evsel.sv
module pmu_evsel #(
    parameter int unsigned NUM_EVT = 16,
    parameter int unsigned SEL_FW  = 8
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic [NUM_EVT-1:0] evt_i,
    input  logic [SEL_FW-1:0]  sel_i,
    input  logic               dur_mode_i,
    input  logic               run_i,
    output logic               inc_o
);
    logic lvl;
    logic prev_q;

    // out-of-range selects leave the level low
    always_comb begin
        lvl = 1'b0;
        for (int i = 0; i < NUM_EVT; i++) begin
            if (sel_i == SEL_FW'(i)) lvl = evt_i[i];
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) prev_q <= 1'b0;
        else       prev_q <= lvl;
    end

    assign inc_o = run_i & (dur_mode_i ? lvl : (lvl & ~prev_q));
endmodule

// File: rtl/pmu_ctrl.sv
module pmu_ctrl
    import pmu_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wr_i,
    input  logic [WORD_W-1:0] wdata_i,
    input  logic [SRC_W-1:0]  wrap_i,
    output pmu_cfg_t          cfg_o,
    output logic [SRC_W-1:0]  flags_o,
    output logic              ev_clr_o,
    output logic              cyc_clr_o,
    output logic              irq_o,
    output logic              fiq_o
);
    pmu_cfg_t         cfg_q;
    logic [SRC_W-1:0] of_q;
    logic [SRC_W-1:0] of_clr;
    logic             pend;
    logic             unused_bits;

    assign unused_bits = ^{wdata_i[7], wdata_i[11], wdata_i[15:14]};

    assign of_clr    = wr_i ? wdata_i[B_OF_LSB +: SRC_W] : '0;
    assign ev_clr_o  = wr_i & wdata_i[B_EVCLR];
    assign cyc_clr_o = wr_i & wdata_i[B_CYCLR];

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cfg_q <= '0;
            of_q  <= '0;
        end else begin
            if (wr_i) cfg_q <= cfg_decode(wdata_i);
            // a fresh overflow beats a clear in the same cycle
            of_q <= (of_q & ~of_clr) | wrap_i;
        end
    end

    assign pend    = |(of_q & cfg_q.ie);
    assign irq_o   = pend & ~cfg_q.route_fiq;
    assign fiq_o   = pend &  cfg_q.route_fiq;
    assign cfg_o   = cfg_q;
    assign flags_o = of_q;
endmodule

// File: rtl/pmu_top.sv
module pmu_top
    import pmu_pkg::*;
#(
    parameter int unsigned CNT_W   = 32,
    parameter int unsigned NUM_EVT = 16
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               priv_i,
    input  logic               dbg_i,
    input  logic               reg_wr_i,
    input  logic               reg_rd_i,
    input  logic [1:0]         reg_idx_i,
    input  logic [31:0]        reg_wdata_i,
    output logic [31:0]        reg_rdata_o,
    input  logic [NUM_EVT-1:0] evt_i,
    output logic               irq_o,
    output logic               fiq_o
);
    reg_idx_e         idx;
    logic             wr_ok;
    logic             ctrl_wr;
    pmu_cfg_t         cfg;
    logic [SRC_W-1:0] of_flags;
    logic [SRC_W-1:0] wraps;
    logic             ev_clr;
    logic             cyc_clr;
    logic             cyc_load;
    logic             cyc_wrap;
    logic [CNT_W-1:0] cyc_cnt;

    logic [NUM_ECH-1:0][CNT_W-1:0] ev_cnt;
    logic [NUM_ECH-1:0]            ev_wrap;
    logic [NUM_ECH-1:0]            ev_inc;
    logic [NUM_ECH-1:0]            ev_load;

    assign idx      = reg_idx_e'(reg_idx_i);
    assign wr_ok    = reg_wr_i & priv_i;
    assign ctrl_wr  = wr_ok && (idx == IDX_CTRL);
    assign cyc_load = wr_ok && (idx == IDX_CYC);

    pmu_ctrl u_ctrl (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .wr_i      (ctrl_wr),
        .wdata_i   (reg_wdata_i),
        .wrap_i    (wraps),
        .cfg_o     (cfg),
        .flags_o   (of_flags),
        .ev_clr_o  (ev_clr),
        .cyc_clr_o (cyc_clr),
        .irq_o     (irq_o),
        .fiq_o     (fiq_o)
    );

    // the cycle counter ignores debug mode
    pmu_counter #(.W(CNT_W)) u_cyc (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .clr_i      (cyc_clr),
        .load_i     (cyc_load),
        .load_val_i (reg_wdata_i[CNT_W-1:0]),
        .inc_i      (cfg.enable),
        .count_o    (cyc_cnt),
        .wrap_o     (cyc_wrap)
    );

    generate
        for (genvar g = 0; g < NUM_ECH; g++) begin : g_ech
            assign ev_load[g] = wr_ok && (reg_idx_i == IDX_W'(int'(IDX_EV0) + g));

            pmu_evsel #(.NUM_EVT(NUM_EVT), .SEL_FW(SEL_FW)) u_sel (
                .clk_i      (clk_i),
                .rst_i      (rst_i),
                .evt_i      (evt_i),
                .sel_i      (cfg.sel[g]),
                .dur_mode_i (cfg.mode[g] == MODE_DUR),
                .run_i      (cfg.enable & ~dbg_i),
                .inc_o      (ev_inc[g])
            );

            pmu_counter #(.W(CNT_W)) u_cnt (
                .clk_i      (clk_i),
                .rst_i      (rst_i),
                .clr_i      (ev_clr),
                .load_i     (ev_load[g]),
                .load_val_i (reg_wdata_i[CNT_W-1:0]),
                .inc_i      (ev_inc[g]),
                .count_o    (ev_cnt[g]),
                .wrap_o     (ev_wrap[g])
            );
        end
    endgenerate

    assign wraps = {cyc_wrap, ev_wrap};

    always_comb begin
        reg_rdata_o = '0;
        if (reg_rd_i && priv_i) begin
            unique case (idx)
                IDX_CTRL: reg_rdata_o = ctrl_encode(cfg, of_flags);
                IDX_CYC:  reg_rdata_o = WORD_W'(cyc_cnt);
                IDX_EV0:  reg_rdata_o = WORD_W'(ev_cnt[0]);
                IDX_EV1:  reg_rdata_o = WORD_W'(ev_cnt[1]);
                default:  reg_rdata_o = '0;
            endcase
        end
    end
endmodule

// File: rtl/pmu_checker.sv
module pmu_checker #(
    parameter int unsigned CNT_W = 32
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             priv_i,
    input logic             dbg_i,
    input logic             reg_wr_i,
    input logic             reg_rd_i,
    input logic [1:0]       reg_idx_i,
    input logic [31:0]      reg_wdata_i,
    input logic [31:0]      reg_rdata_o,
    input logic             irq_o,
    input logic             fiq_o,
    input logic             enable,
    input logic [2:0]       flags,
    input logic [CNT_W-1:0] cyc_cnt,
    input logic [CNT_W-1:0] ev0,
    input logic [CNT_W-1:0] ev1,
    input logic             cyc_load,
    input logic             cyc_clr
);
    logic cyc_flag_clr;
    assign cyc_flag_clr = reg_wr_i && priv_i && (reg_idx_i == 2'd0) && reg_wdata_i[10];

    a_r1_reset_clear: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> (cyc_cnt == '0 && ev0 == '0 && ev1 == '0 && !irq_o && !fiq_o));

    a_r3_cycle_step: assert property (@(posedge clk_i) disable iff (rst_i)
        (enable && !cyc_clr && !cyc_load) |=> (cyc_cnt == CNT_W'($past(cyc_cnt) + 1'b1)));

    a_r3_cycle_wrap: assert property (@(posedge clk_i) disable iff (rst_i)
        (enable && !cyc_clr && !cyc_load && (&cyc_cnt)) |=> (cyc_cnt == '0 && flags[2]));

    a_r8_flag_sticky: assert property (@(posedge clk_i) disable iff (rst_i)
        (flags[2] && !cyc_flag_clr) |=> flags[2]);

    a_r10_one_output: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0({irq_o, fiq_o}));

    a_r11_unpriv_read: assert property (@(posedge clk_i) disable iff (rst_i)
        (reg_rd_i && !priv_i) |-> (reg_rdata_o == '0));

    a_r6_dbg_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        (dbg_i && !reg_wr_i) |=> ($stable(ev0) && $stable(ev1)));
endmodule

bind pmu_top pmu_checker #(.CNT_W(CNT_W)) u_chk (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .priv_i      (priv_i),
    .dbg_i       (dbg_i),
    .reg_wr_i    (reg_wr_i),
    .reg_rd_i    (reg_rd_i),
    .reg_idx_i   (reg_idx_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .irq_o       (irq_o),
    .fiq_o       (fiq_o),
    .enable      (cfg.enable),
    .flags       (of_flags),
    .cyc_cnt     (cyc_cnt),
    .ev0         (ev_cnt[0]),
    .ev1         (ev_cnt[1]),
    .cyc_load    (cyc_load),
    .cyc_clr     (cyc_clr)
);

// File: tb/pmu_top_tb_top.sv
`timescale 1ns/1ps
module pmu_top_tb_top;
    localparam int CW   = 8;
    localparam int NE   = 4;
    localparam int MAXV = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic          priv = 1'b1;
    logic          dbg  = 1'b0;
    logic          wr   = 1'b0;
    logic          rd   = 1'b0;
    logic [1:0]    idx  = 2'd0;
    logic [31:0]   wd   = 32'd0;
    logic [NE-1:0] evt  = '0;
    logic [31:0]   rdata;
    logic          irq, fiq;

    pmu_top #(.CNT_W(CW), .NUM_EVT(NE)) dut_i (
        .clk_i(clk), .rst_i(rst), .priv_i(priv), .dbg_i(dbg),
        .reg_wr_i(wr), .reg_rd_i(rd), .reg_idx_i(idx), .reg_wdata_i(wd),
        .reg_rdata_o(rdata), .evt_i(evt), .irq_o(irq), .fiq_o(fiq)
    );

    int    checks = 0;
    int    errors = 0;
    bit    done   = 0;
    string tag    = "R1";

    // behavioural reference state
    int       m_cyc = 0;
    int       m_ev[2]   = '{0, 0};
    bit       m_prev[2] = '{0, 0};
    int       m_sel[2]  = '{0, 0};
    bit       m_en = 0, m_route = 0;
    bit [2:0] m_ie = 0, m_of = 0;
    bit [1:0] m_mode = 0;

    function automatic logic [31:0] m_ctrl();
        logic [31:0] w;
        w = '0;
        w[0]     = m_en;
        w[3]     = m_route;
        w[6:4]   = m_ie;
        w[10:8]  = m_of;
        w[13:12] = m_mode;
        w[23:16] = 8'(m_sel[0]);
        w[31:24] = 8'(m_sel[1]);
        return w;
    endfunction

    function automatic logic [31:0] cw(bit en, bit rt, bit [2:0] ie, bit [2:0] w1c,
                                       bit [1:0] md, int s0, int s1, bit ecl, bit ccl);
        logic [31:0] w;
        w = '0;
        w[0] = en; w[1] = ecl; w[2] = ccl; w[3] = rt;
        w[6:4] = ie; w[10:8] = w1c; w[13:12] = md;
        w[23:16] = 8'(s0); w[31:24] = 8'(s1);
        return w;
    endfunction

    task automatic check(string t, logic [31:0] act, logic [31:0] exp, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", t, what, act, exp);
        end
    endtask

    task automatic step();
        logic [31:0] er;
        bit          pend, wr_ok, lvl, inc;
        int          n_cyc;
        int          n_ev[2];
        bit          n_prev[2];
        bit [2:0]    ovf, n_of;
        #1;
        er = '0;
        if (rd && priv) begin
            case (idx)
                2'd0: er = m_ctrl();
                2'd1: er = 32'(m_cyc);
                2'd2: er = 32'(m_ev[0]);
                default: er = 32'(m_ev[1]);
            endcase
        end
        if (rd) check(tag, rdata, er, $sformatf("read idx %0d", idx));
        pend = |(m_of & m_ie);
        check("R10", {31'b0, irq}, {31'b0, pend && !m_route}, "irq_o");
        check("R10", {31'b0, fiq}, {31'b0, pend &&  m_route}, "fiq_o");

        wr_ok = wr && priv;
        ovf   = 3'b000;
        n_cyc = m_cyc;
        if (wr_ok && idx == 2'd0 && wd[2])  n_cyc = 0;
        else if (wr_ok && idx == 2'd1)      n_cyc = int'(wd) & MAXV;
        else if (m_en) begin
            if (m_cyc == MAXV) begin n_cyc = 0; ovf[2] = 1'b1; end
            else n_cyc = m_cyc + 1;
        end
        for (int i = 0; i < 2; i++) begin
            lvl = (m_sel[i] < NE) ? evt[m_sel[i]] : 1'b0;
            inc = m_en && !dbg && (m_mode[i] ? lvl : (lvl && !m_prev[i]));
            n_ev[i]   = m_ev[i];
            n_prev[i] = lvl;
            if (wr_ok && idx == 2'd0 && wd[1])  n_ev[i] = 0;
            else if (wr_ok && idx == 2'(2 + i)) n_ev[i] = int'(wd) & MAXV;
            else if (inc) begin
                if (m_ev[i] == MAXV) begin n_ev[i] = 0; ovf[i] = 1'b1; end
                else n_ev[i] = m_ev[i] + 1;
            end
        end
        n_of = m_of;
        if (wr_ok && idx == 2'd0) n_of = n_of & ~wd[10:8];
        n_of = n_of | ovf;

        @(posedge clk);
        m_cyc = n_cyc;
        m_ev  = n_ev;
        m_prev = n_prev;
        m_of  = n_of;
        if (wr_ok && idx == 2'd0) begin
            m_en = wd[0]; m_route = wd[3]; m_ie = wd[6:4]; m_mode = wd[13:12];
            m_sel[0] = int'(wd[23:16]); m_sel[1] = int'(wd[31:24]);
        end
        @(negedge clk);
    endtask

    task automatic wreg(int i, logic [31:0] v);
        wr = 1'b1; rd = 1'b1; idx = 2'(i); wd = v;
        step();
        wr = 1'b0; wd = '0;
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) begin
            rd = 1'b1; idx = 2'(k % 4);
            step();
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state on every register and both interrupt lines
        tag = "R1"; idle(4);

        // R2: direct loads and zero-extended reads, high bits dropped
        tag = "R2";
        wreg(1, 32'h55); wreg(2, 32'h12); wreg(3, 32'h34); idle(4);
        wreg(1, 32'h1AB); idle(2);

        // R3: free running cycle counter wraps and flags bit 10
        tag = "R3";
        wreg(1, 32'hF0);
        wreg(0, cw(1, 0, 3'b100, 3'b000, 2'b00, 0, 0, 0, 0));
        idle(20);

        // R8: W1C clears the flag, then a clear that collides with a wrap
        tag = "R8";
        wreg(0, cw(1, 0, 3'b100, 3'b100, 2'b00, 0, 0, 0, 0)); idle(2);
        wreg(1, 32'hFD); idle(2);
        wreg(0, cw(1, 0, 3'b100, 3'b100, 2'b00, 0, 0, 0, 0)); idle(3);

        // R4: occurrence counting on line 1, out-of-range select on counter 1
        tag = "R4";
        wreg(0, cw(1, 0, 3'b000, 3'b111, 2'b00, 1, 7, 1, 0));
        for (int k = 0; k < 24; k++) begin
            evt = ((k % 5) < 3) ? 4'b1111 : 4'b0000;
            if (k % 7 == 6) evt = 4'b0000;
            rd = 1'b1; idx = 2'(2 + (k % 2));
            step();
        end
        evt = '0;

        // R5: duration counting on line 2
        tag = "R5";
        wreg(0, cw(1, 0, 3'b000, 3'b000, 2'b10, 1, 2, 0, 0));
        for (int k = 0; k < 20; k++) begin
            evt = {1'b0, (k % 3) != 0, (k % 2) == 0, 1'b0};
            rd = 1'b1; idx = 2'(1 + (k % 3));
            step();
        end

        // R6: debug mode freezes event counters, cycle counter runs
        tag = "R6";
        dbg = 1'b1;
        for (int k = 0; k < 10; k++) begin
            evt = 4'(k);
            rd = 1'b1; idx = 2'(1 + (k % 3));
            step();
        end
        dbg = 1'b0; evt = '0;

        // R7: self-clearing reset bits
        tag = "R7";
        wreg(0, cw(1, 0, 3'b000, 3'b000, 2'b10, 1, 2, 1, 0)); idle(4);
        wreg(0, cw(1, 0, 3'b000, 3'b000, 2'b10, 1, 2, 0, 1)); idle(4);

        // R9: event counters count through their wrap, fast route
        tag = "R9";
        evt = 4'b0001;
        wreg(0, cw(1, 1, 3'b011, 3'b111, 2'b11, 0, 0, 0, 0));
        wreg(2, 32'hFC); wreg(3, 32'hFE);
        idle(12);

        // R10: move the request to the normal output, then mask it
        tag = "R10";
        wreg(0, cw(1, 0, 3'b011, 3'b000, 2'b11, 0, 0, 0, 0)); idle(3);
        wreg(0, cw(1, 0, 3'b000, 3'b000, 2'b11, 0, 0, 0, 0)); idle(3);
        wreg(0, cw(1, 1, 3'b011, 3'b000, 2'b11, 0, 0, 0, 0)); idle(3);

        // R11: unprivileged writes ignored, reads zero
        tag = "R11";
        priv = 1'b0;
        wreg(0, 32'h0); wreg(1, 32'h3); wreg(2, 32'h3); idle(4);
        priv = 1'b1;
        idle(4);

        // R12: write beats increment, including on the wrap cycle; enable off holds
        tag = "R12";
        wreg(0, cw(1, 0, 3'b111, 3'b111, 2'b11, 0, 0, 0, 0));
        wreg(1, 32'hFE); idle(1);
        wreg(1, 32'h10); idle(2);
        wreg(2, 32'hFF); idle(2);
        wreg(2, 32'h80); idle(2);
        wreg(0, cw(0, 0, 3'b111, 3'b111, 2'b11, 0, 0, 0, 0));
        idle(8);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog run did not complete actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule